// File: doc/BRIEF.md
# Memory Access and Next Program Counter Selection

This block sits between the execute stage and the data memory of a processor that completes one instruction per clock. It looks at the instruction class code, the branch outcome and the values produced by earlier stages. From these it forms the data-memory address, the store data and the read and write strobes. It also chooses the next instruction address from one of three sources and keeps it in the program counter register.

All memory and selection outputs are combinational functions of the current inputs. The program counter is the only state. It advances on every rising clock edge while the run-permit input is high, keeps its value while that input is low, and clears to zero on reset. This is a control path and not a data stream, so every pin is a plain level with no handshake.

The class code encoding is: 0 halt, 1 no-op, 2 conditional move, 3 immediate load, 4 store, 5 load, 6 arithmetic/logic, 7 jump, 8 call, 9 return, 10 push, 11 pop.

Top module: `mem_pc_select`

## Requirements
- R1: `mem_read` is 1 exactly when `icode` is 5 (load), 11 (pop) or 9 (return), and 0 for every other code.
- R2: `mem_write` is 1 exactly when `icode` is 4 (store), 10 (push) or 8 (call). `mem_read` and `mem_write` are never both 1.
- R3: `mem_addr` equals `val_a` when `icode` is 11 or 9, and equals `val_e` for every other code.
- R4: `mem_wdata` equals `val_p` when `icode` is 8, and equals `val_a` for every other code.
- R5: When `icode` is 9 and `run_ok` is 1, `pc` equals `val_m` after the next rising edge.
- R6: When `icode` is 8 and `run_ok` is 1, `pc` equals `val_c` after the next rising edge, whatever `cnd` is.
- R7: When `icode` is 7 and `run_ok` is 1, `pc` becomes `val_c` if `cnd` is 1 and `val_p` if `cnd` is 0.
- R8: For every code other than 7, 8 and 9, with `run_ok` at 1, `pc` becomes `val_p` after the next rising edge.
- R9: While `rst_n` is 0, `pc` is 0.
- R10: On a rising edge where `run_ok` is 0, `pc` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_ok | input | 1 | Processor status is normal; the PC may advance |
| icode | input | 4 | Instruction class code |
| cnd | input | 1 | Branch condition outcome |
| val_a | input | 64 | Register operand A |
| val_c | input | 64 | Immediate constant or target address |
| val_e | input | 64 | ALU result |
| val_m | input | 64 | Data read back from memory |
| val_p | input | 64 | Address of the sequentially next instruction |
| mem_addr | output | 64 | Data-memory address |
| mem_wdata | output | 64 | Data-memory store data |
| mem_read | output | 1 | Data-memory read strobe |
| mem_write | output | 1 | Data-memory write strobe |
| pc | output | 64 | Program counter |

## Verification
The assertions check on every cycle that read and write never assert together. They also check that a call presents the return address as store data and that stack-pop style reads take their address from operand A. Across each clock edge they check that return and call load the PC from the right source and that a low run permit freezes the PC. The bench's scenarios alone show that the strobes are decoded for every one of the twelve codes. The same holds for the taken and not-taken jump paths, the default sequential path, and the reset value.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic [3:0] {
    IC_HALT  = 4'h0,
    IC_NOP   = 4'h1,
    IC_CMOV  = 4'h2,
    IC_IMM   = 4'h3,
    IC_STORE = 4'h4,
    IC_LOAD  = 4'h5,
    IC_ALU   = 4'h6,
    IC_JUMP  = 4'h7,
    IC_CALL  = 4'h8,
    IC_RET   = 4'h9,
    IC_PUSH  = 4'hA,
    IC_POP   = 4'hB
  } icode_e;

  localparam int unsigned ICODE_W = 4;

  typedef enum logic [1:0] {
    PC_SRC_SEQ = 2'd0,
    PC_SRC_CONST = 2'd1,
    PC_SRC_MEM = 2'd2
  } pc_src_e;
endpackage

// File: rtl/mem_sel.sv
module mem_sel
  import mpc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [ICODE_W-1:0] icode,
  input  logic [W-1:0]       val_a,
  input  logic [W-1:0]       val_e,
  input  logic [W-1:0]       val_p,
  output logic [W-1:0]       addr,
  output logic [W-1:0]       wdata,
  output logic               rd,
  output logic               wr
);
  logic addr_from_a;

  always_comb begin
    rd          = (icode == IC_LOAD) || (icode == IC_POP) || (icode == IC_RET);
    wr          = (icode == IC_STORE) || (icode == IC_PUSH) || (icode == IC_CALL);
    addr_from_a = (icode == IC_POP) || (icode == IC_RET);
    addr        = addr_from_a ? val_a : val_e;
    wdata       = (icode == IC_CALL) ? val_p : val_a;
  end

  // R2: read and write strobes are mutually exclusive
  always_comb begin
    p_rd_wr_excl_r2: assert (!(rd && wr));
  end
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import mpc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [ICODE_W-1:0] icode,
  input  logic               cnd,
  input  logic [W-1:0]       val_c,
  input  logic [W-1:0]       val_m,
  input  logic [W-1:0]       val_p,
  output logic [W-1:0]       next_pc
);
  pc_src_e src;

  always_comb begin
    unique case (icode)
      IC_RET:  src = PC_SRC_MEM;
      IC_CALL: src = PC_SRC_CONST;
      IC_JUMP: src = cnd ? PC_SRC_CONST : PC_SRC_SEQ;
      default: src = PC_SRC_SEQ;
    endcase
  end

  always_comb begin
    case (src)
      PC_SRC_MEM:   next_pc = val_m;
      PC_SRC_CONST: next_pc = val_c;
      default:      next_pc = val_p;
    endcase
  end
endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
  parameter int unsigned W        = 64,
  parameter logic [W-1:0] RESET_PC = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_ok,
  input  logic [W-1:0] next_pc,
  output logic [W-1:0] pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= RESET_PC;
    else if (run_ok) pc <= next_pc;
  end

  // R10: no advance without run permit
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> $stable(pc));
endmodule

// File: rtl/mem_pc_select.sv
module mem_pc_select
  import mpc_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_ok,
  input  logic [3:0]   icode,
  input  logic         cnd,
  input  logic [W-1:0] val_a,
  input  logic [W-1:0] val_c,
  input  logic [W-1:0] val_e,
  input  logic [W-1:0] val_m,
  input  logic [W-1:0] val_p,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_read,
  output logic         mem_write,
  output logic [W-1:0] pc
);
  logic [W-1:0] next_pc;

  mem_sel #(.W(W)) u_mem_sel (
    .icode(icode), .val_a(val_a), .val_e(val_e), .val_p(val_p),
    .addr(mem_addr), .wdata(mem_wdata), .rd(mem_read), .wr(mem_write)
  );

  pc_next_sel #(.W(W)) u_pc_next_sel (
    .icode(icode), .cnd(cnd), .val_c(val_c), .val_m(val_m), .val_p(val_p),
    .next_pc(next_pc)
  );

  pc_reg #(.W(W)) u_pc_reg (
    .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .next_pc(next_pc), .pc(pc)
  );

  p_ret_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && icode == IC_RET) |=> (pc == $past(val_m)));

  p_call_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && icode == IC_CALL) |=> (pc == $past(val_c)));

  p_call_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_CALL) |-> (mem_write && mem_wdata == val_p));

  p_stack_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_POP || icode == IC_RET) |-> (mem_read && mem_addr == val_a));
endmodule

// File: tb/mem_pc_select_bench.sv
module mem_pc_select_bench;
  localparam int unsigned W = 64;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run_ok = 1'b0;
  logic [3:0]   icode = 4'h1;
  logic         cnd = 1'b0;
  logic [W-1:0] val_a = '0, val_c = '0, val_e = '0, val_m = '0, val_p = '0;
  logic [W-1:0] mem_addr, mem_wdata, pc;
  logic         mem_read, mem_write;

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] pc_model = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_pc_select #(.W(W)) u_mem_pc_select (
    .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .icode(icode), .cnd(cnd),
    .val_a(val_a), .val_c(val_c), .val_e(val_e), .val_m(val_m), .val_p(val_p),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_read(mem_read),
    .mem_write(mem_write), .pc(pc)
  );

  function automatic bit exp_rd(input logic [3:0] ic);
    return ic == 4'h5 || ic == 4'hB || ic == 4'h9;
  endfunction
  function automatic bit exp_wr(input logic [3:0] ic);
    return ic == 4'h4 || ic == 4'hA || ic == 4'h8;
  endfunction
  function automatic logic [W-1:0] exp_addr(input logic [3:0] ic, input logic [W-1:0] a, e);
    return (ic == 4'hB || ic == 4'h9) ? a : e;
  endfunction
  function automatic logic [W-1:0] exp_wdata(input logic [3:0] ic, input logic [W-1:0] a, p);
    return (ic == 4'h8) ? p : a;
  endfunction
  function automatic logic [W-1:0] exp_next(input logic [3:0] ic, input logic c,
                                            input logic [W-1:0] cv, m, p);
    if (ic == 4'h9) return m;
    if (ic == 4'h8) return cv;
    if (ic == 4'h7) return c ? cv : p;
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string pc_req(input logic [3:0] ic, input logic ok);
    if (!ok) return "R10";
    if (ic == 4'h9) return "R5";
    if (ic == 4'h8) return "R6";
    if (ic == 4'h7) return "R7";
    return "R8";
  endfunction

  task automatic step(input logic [3:0] ic, input logic c, input logic ok);
    logic [W-1:0] expn;
    @(negedge clk);
    icode = ic; cnd = c; run_ok = ok;
    val_a = {$urandom, $urandom}; val_c = {$urandom, $urandom};
    val_e = {$urandom, $urandom}; val_m = {$urandom, $urandom};
    val_p = {$urandom, $urandom};
    #1;
    chk(mem_read == exp_rd(ic), "R1", W'(mem_read), W'(exp_rd(ic)));
    chk(mem_write == exp_wr(ic), "R2", W'(mem_write), W'(exp_wr(ic)));
    chk(!(mem_read && mem_write), "R2", W'(mem_read & mem_write), '0);
    chk(mem_addr == exp_addr(ic, val_a, val_e), "R3", mem_addr, exp_addr(ic, val_a, val_e));
    chk(mem_wdata == exp_wdata(ic, val_a, val_p), "R4", mem_wdata, exp_wdata(ic, val_a, val_p));
    expn = ok ? exp_next(ic, c, val_c, val_m, val_p) : pc_model;
    @(posedge clk);
    #1;
    pc_model = expn;
    chk(pc == pc_model, pc_req(ic, ok), pc, pc_model);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(pc == '0, "R9", pc, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // directed corners
    step(4'h9, 1'b0, 1'b1);   // R5 return
    step(4'h8, 1'b0, 1'b1);   // R6 call, cnd low
    step(4'h7, 1'b1, 1'b1);   // R7 taken
    step(4'h7, 1'b0, 1'b1);   // R7 not taken
    step(4'h6, 1'b1, 1'b1);   // R8 sequential
    step(4'h9, 1'b1, 1'b0);   // R10 hold
    step(4'h7, 1'b1, 1'b0);   // R10 hold
    for (int ic = 0; ic < 12; ic++) step(4'(ic), 1'b1, 1'b1);
    for (int i = 0; i < 400; i++)
      step(4'($urandom_range(11, 0)), 1'($urandom), ($urandom_range(3, 0) != 0));
    // reset in mid-run returns PC to zero (R9)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(pc == '0, "R9", pc, '0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule